// File: doc/BRIEF.md
# Microsecond Free-Running Timer with Periodic Tap Interrupts

This block keeps a 12-bit count that advances once per microsecond and never reloads. A prescaler divides the system clock by a parameter (six by default, for a 6 MHz clock) to produce the one-microsecond step. The count wraps every 4096 µs, so firmware can time an event of up to about 4 ms by taking the difference of two readings.

The block gives two periodic interrupt requests, each one clock wide. The fast request comes every 128 µs, when the low seven count bits roll over to zero. The slow request comes every 1024 µs, when the low ten bits roll over to zero.

Firmware reads the count in two parts. The low byte is always live. A read strobe on the low byte copies the upper four bits into a holding register, and the high output always shows that register. A low read followed by a high read therefore gives one consistent 12-bit value.

Top module: `free_timer`

## Requirements
- R1: While reset is high, the count, the prescaler and the holding register clear. The low byte and the high output read 0, and neither interrupt pulses in a reset cycle, even one where a tap would otherwise have fired.
- R2: After reset is released, the count advances by exactly one every CLK_DIV clock cycles. After k rising edges out of reset, the low byte equals floor(k / CLK_DIV) mod 256.
- R3: The 12-bit count runs freely and wraps from 4095 to 0 with no reload.
- R4: The fast interrupt goes high for the cycle in which the low 7 count bits have just rolled from 127 to 0, which is once every 128 count steps.
- R5: The slow interrupt goes high for the cycle in which the low 10 count bits have just rolled from 1023 to 0, which is once every 1024 count steps. It always coincides with a fast pulse.
- R6: At the clock edge where the low-read strobe is high, the count's bits [11:8] are copied into the holding register. The high output equals that register and does not change until the next low-read strobe or reset.
- R7: Each interrupt pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| lo_rd_i | input | 1 | Low-byte read strobe; captures the upper count bits |
| cnt_lo_o | output | 8 | Live count bits [7:0] |
| cnt_hi_o | output | 4 | Held count bits [11:8] |
| irq_fast_o | output | 1 | One-cycle pulse every 128 count steps |
| irq_slow_o | output | 1 | One-cycle pulse every 1024 count steps |

## Verification
The assertions assume three things about the inputs:
- Reset is driven to a known level from the first edge.
- The read strobe is a clean synchronous level.
- CLK_DIV is at least 1.

When CLK_DIV is 1 the count steps on every cycle. The single-pulse property still holds in that case, because a tap fires only once per 128 steps.

The bench sweeps more than two full counter wraps at the default divisor and compares every output on every cycle with values computed from the elapsed edge count. It issues read strobes at a spacing that does not divide the tap periods, so the captures land at many different count phases. It applies reset in the exact cycle where a fast tap is due, to show that reset suppresses the pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef struct packed {
        logic slow;
        logic fast;
    } tmr_irq_t;

    function automatic int div_bits(input int div);
        return (div > 1) ? $clog2(div) : 1;
    endfunction

    function automatic int pick_tap(input int idx, input int w_fast, input int w_slow);
        return (idx == 0) ? w_fast : w_slow;
    endfunction

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 6
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int PW = tmr_pkg::div_bits(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    assign tick_o = (pre_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)         pre_q <= '0;
        else if (tick_o) pre_q <= '0;
        else             pre_q <= pre_q + 1'b1;
    end

    // R2: prescaler never leaves its range
    a_r2_pre_range: assert property (@(posedge clk) disable iff (rst) pre_q <= LAST);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick_i,
    output logic [W-1:0] count_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_q + 1'b1;
    end

    assign count_o = cnt_q;

    a_r2_holds_without_tick: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(cnt_q));
    a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        (tick_i && (&cnt_q)) |=> (cnt_q == '0));
endmodule

// File: rtl/tmr_taps.sv
module tmr_taps #(
    parameter int FAST_W = 7,
    parameter int SLOW_W = 10
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          tick_i,
    input  logic [SLOW_W-1:0]             cnt_i,
    output tmr_pkg::tmr_irq_t             irq_o
);
    logic [1:0] irq_q;

    for (genvar g = 0; g < 2; g++) begin : g_tap
        localparam int TW = tmr_pkg::pick_tap(g, FAST_W, SLOW_W);
        always_ff @(posedge clk) begin
            if (rst) irq_q[g] <= 1'b0;
            else     irq_q[g] <= tick_i && (&cnt_i[TW-1:0]);
        end
        a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
            irq_q[g] |=> !irq_q[g]);
    end

    assign irq_o.fast = irq_q[0];
    assign irq_o.slow = irq_q[1];

    // R5: slow tap coincides with a fast tap
    a_r5_slow_nested: assert property (@(posedge clk) disable iff (rst)
        irq_o.slow |-> irq_o.fast);
    // R4: fast pulse follows a step out of an all-ones low field
    a_r4_fast_cause: assert property (@(posedge clk) disable iff (rst)
        (tick_i && (&cnt_i[FAST_W-1:0])) |=> irq_o.fast);
endmodule

// File: rtl/tmr_hold.sv
module tmr_hold #(
    parameter int HW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rd_i,
    input  logic [HW-1:0] hi_i,
    output logic [HW-1:0] hi_o
);
    logic [HW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)       hold_q <= '0;
        else if (rd_i) hold_q <= hi_i;
    end

    assign hi_o = hold_q;

    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !rd_i |=> $stable(hold_q));
    a_r6_capture: assert property (@(posedge clk) disable iff (rst)
        rd_i |=> (hold_q == $past(hi_i)));
endmodule

// File: rtl/free_timer.sv
module free_timer #(
    parameter int CLK_DIV = 6,
    parameter int CNT_W   = 12,
    parameter int LO_W    = 8,
    parameter int FAST_W  = 7,
    parameter int SLOW_W  = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 lo_rd_i,
    output logic [LO_W-1:0]      cnt_lo_o,
    output logic [CNT_W-LO_W-1:0] cnt_hi_o,
    output logic                 irq_fast_o,
    output logic                 irq_slow_o
);
    localparam int HI_W = CNT_W - LO_W;

    logic              tick;
    logic [CNT_W-1:0]  count;
    tmr_pkg::tmr_irq_t irq;

    tmr_prescale #(.DIV(CLK_DIV)) u_pre (
        .clk(clk), .rst(rst), .tick_o(tick)
    );

    tmr_count #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick_i(tick), .count_o(count)
    );

    tmr_taps #(.FAST_W(FAST_W), .SLOW_W(SLOW_W)) u_taps (
        .clk(clk), .rst(rst), .tick_i(tick),
        .cnt_i(count[SLOW_W-1:0]), .irq_o(irq)
    );

    tmr_hold #(.HW(HI_W)) u_hold (
        .clk(clk), .rst(rst), .rd_i(lo_rd_i),
        .hi_i(count[CNT_W-1:LO_W]), .hi_o(cnt_hi_o)
    );

    assign cnt_lo_o   = count[LO_W-1:0];
    assign irq_fast_o = irq.fast;
    assign irq_slow_o = irq.slow;

    // R1: reset leaves cleared outputs and no pulse
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (cnt_lo_o == '0 && cnt_hi_o == '0 && !irq_fast_o && !irq_slow_o));
endmodule

// File: tb/free_timer_tb_top.sv
module free_timer_tb_top;
    localparam int DIV  = 6;
    localparam int CYC  = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lo_rd = 1'b0;
    logic [7:0] cnt_lo;
    logic [3:0] cnt_hi;
    logic       irq_fast, irq_slow;

    int errors = 0;
    int checks = 0;
    int k = 0;
    int exp_hold = 0;
    int pend_hold = 0;
    bit pend = 0;

    always #(CYC/2) clk = ~clk;

    free_timer dut_i (
        .clk(clk), .rst(rst), .lo_rd_i(lo_rd),
        .cnt_lo_o(cnt_lo), .cnt_hi_o(cnt_hi),
        .irq_fast_o(irq_fast), .irq_slow_o(irq_slow)
    );

    function automatic int cnt_at(input int e);
        return (e / DIV) % 4096;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s k=%0d actual=%0d expected=%0d", req, k, act, exp);
        end
    endtask

    task automatic check_all();
        int c;
        bit fire;
        c = cnt_at(k);
        fire = (k > 0) && (k % DIV == 0);
        if (c == 0 && fire) chk("R3 wrap", cnt_lo, 0);
        else                chk("R2 low byte", cnt_lo, c % 256);
        chk("R4/R7 fast irq", irq_fast, (fire && c % 128 == 0) ? 1 : 0);
        chk("R5/R7 slow irq", irq_slow, (fire && c % 1024 == 0) ? 1 : 0);
        chk("R6 high hold", cnt_hi, exp_hold);
    endtask

    task automatic run(input int n, input int rd_gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            k++;
            if (pend) begin exp_hold = pend_hold; pend = 0; end
            lo_rd = 1'b0;
            check_all();
            if (rd_gap > 0 && (k % rd_gap) == 0) begin
                lo_rd = 1'b1;
                pend = 1;
                pend_hold = cnt_at(k) / 256;
            end
        end
    endtask

    task automatic do_reset(input int n);
        rst = 1'b1;
        lo_rd = 1'b0;
        pend = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk("R1 reset low", cnt_lo, 0);
            chk("R1 reset high", cnt_hi, 0);
            chk("R1 reset fast", irq_fast, 0);
            chk("R1 reset slow", irq_slow, 0);
        end
        rst = 1'b0;
        k = 0;
        exp_hold = 0;
    endtask

    initial begin
        #(CYC * 190000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(3);
        // two full wraps plus margin, reads at an odd spacing
        run(2 * 4096 * DIV + 50, 37);
        // reset arriving exactly when a fast tap is due (R1)
        do_reset(2);
        run(6 * 127 + 5, 0);
        do_reset(3);
        run(900, 53);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule